// File: doc/BRIEF.md
# Frame Interrupt Coalescing Unit

The block collects frame-completion pulses from the receive and transmit paths of a network controller and defers the frame interrupt of each direction. When coalescing is enabled for a direction, its event bit is set on whichever comes first. One trigger is the frame counter reaching a programmed threshold. The other is a timeout that starts with the first frame still waiting for an interrupt. When coalescing is disabled, every completion sets the event bit at once.

Each direction has its own 32-bit setting word, which holds an enable, a timer clock select, a frame threshold and a timer threshold. The timer threshold is counted in ticks of 64 counted clocks. As an example, 1000 µs at a 125 MHz count clock is programmed as 1953.

The event bits live in a 32-bit event register that software clears by writing 1s. A 32-bit mask register chooses which set bits drive the single interrupt line. Other logic on the chip produces the completion pulses and receives the interrupt line.

Top module: `irq_coal_top`

## Requirements
- R1: After reset, the event register, the mask register and both setting words are zero. Coalescing is therefore off and `irq_o` is low.
- R2: With coalescing disabled (setting bit 31 = 0), a frame pulse sets its event bit on the same clock edge: receive sets bit 25 and transmit sets bit 27.
- R3: Setting word layout: bit 31 enables coalescing, bit 30 selects the timer clock, bits [29:20] hold the frame threshold and bits [19:0] hold the timer threshold.
- R4: With coalescing enabled, the event bit is set on the edge that samples the frame which brings the count to the frame threshold. A threshold of 0 behaves as 1.
- R5: With coalescing enabled, the event bit is set 64×T counted cycles after the edge that sampled the first waiting frame, where T is the timer threshold. Later frames do not restart the timer, and the timer counts only while at least one frame is waiting.
- R6: With bit 30 = 1, the timer counts only the cycles in which `alt_tick_i` is high. With bit 30 = 0, it counts every cycle.
- R7: When a coalesced event fires, that direction's frame count and timer return to zero. Any write of the setting word also zeroes them, so frames waiting before the write are dropped.
- R8: Writing 1s through `evt_clr_i` clears the matching event bits. A set and a clear of the same bit in the same cycle leave the bit set.
- R9: `irq_o` is high exactly when some event bit is set whose mask bit is 1. An event bit rises only when its direction fires.
- R10: The receive and transmit directions coalesce independently, each under its own setting word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 2 | Setting word write strobe; bit 0 receive, bit 1 transmit |
| cfg_wdata_i | input | 32 | Setting word data |
| rx_frame_i | input | 1 | Receive frame completion pulse |
| tx_frame_i | input | 1 | Transmit frame completion pulse |
| alt_tick_i | input | 1 | Count enable for the alternate timer clock |
| evt_clr_we_i | input | 1 | Event clear strobe |
| evt_clr_i | input | 32 | Bits to clear in the event register |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_i | input | 32 | Mask register data |
| evt_o | output | 32 | Event register |
| irq_o | output | 1 | Masked interrupt line |

## Verification
A single pulse in disabled mode checks that there is no delay. A burst that reaches the frame threshold, followed by a second burst, shows that the count restarts after a fire. A lone frame under a small timer threshold, with a later frame inside the window, shows that the timer runs from the first waiting frame and is not restarted. Holding the alternate tick low and then high checks the clock select, and a setting rewrite between frames shows that waiting frames are dropped. Each expected event is tied to an exact cycle, so an off-by-one in the prescaler, the count or the threshold compare shifts the event and is detected.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
  parameter int unsigned CFG_W  = 32;
  parameter int unsigned EN_BIT = 31;
  parameter int unsigned CS_BIT = 30;
  parameter int unsigned FT_LSB = 20;
  parameter int unsigned FT_W   = CS_BIT - FT_LSB;
  parameter int unsigned TT_W   = FT_LSB;

  typedef struct packed {
    logic            en;
    logic            cs;
    logic [FT_W-1:0] ft;
    logic [TT_W-1:0] tt;
  } coal_cfg_t;

  function automatic coal_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
    coal_cfg_t c;
    c.en = w[EN_BIT];
    c.cs = w[CS_BIT];
    c.ft = w[FT_LSB +: FT_W];
    c.tt = w[0 +: TT_W];
    return c;
  endfunction
endpackage

// File: rtl/irq_coal_prescale.sv
module irq_coal_prescale #(
  parameter int unsigned DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  assign tick_o = adv_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (adv_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/irq_coal_unit.sv
module irq_coal_unit
  import irq_coal_pkg::*;
#(
  parameter int unsigned DIV = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             frame_i,
  input  logic             alt_tick_i,
  output logic             fire_o,
  output logic             pend_o,
  output logic             en_o
);
  coal_cfg_t       cfg_q;
  logic [FT_W-1:0] cnt_q;
  logic [TT_W-1:0] tcnt_q;
  logic [FT_W-1:0] thr;
  logic [FT_W:0]   cnt_sum;
  logic [TT_W:0]   tcnt_nxt;
  logic            adv, tick, frame_hit, time_hit;

  assign thr      = (cfg_q.ft == '0) ? FT_W'(1) : cfg_q.ft;
  assign pend_o   = (cnt_q != '0);
  assign en_o     = cfg_q.en;
  assign cnt_sum  = {1'b0, cnt_q} + {{FT_W{1'b0}}, frame_i};
  assign tcnt_nxt = {1'b0, tcnt_q} + 1'b1;
  assign adv      = cfg_q.en && pend_o && (cfg_q.cs ? alt_tick_i : 1'b1);

  irq_coal_prescale #(.DIV(DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!pend_o || fire_o || cfg_we_i),
    .adv_i (adv),
    .tick_o(tick)
  );

  assign frame_hit = frame_i && (cnt_sum >= {1'b0, thr});
  assign time_hit  = tick && (tcnt_nxt >= {1'b0, cfg_q.tt});
  // disabled: pass through; enabled: a setting write wins over a fire
  assign fire_o = cfg_q.en ? (!cfg_we_i && (frame_hit || time_hit)) : frame_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      cnt_q  <= '0;
      tcnt_q <= '0;
    end else if (cfg_we_i) begin
      cfg_q  <= decode_cfg(cfg_wdata_i);
      cnt_q  <= '0;
      tcnt_q <= '0;
    end else if (!cfg_q.en || fire_o) begin
      cnt_q  <= '0;
      tcnt_q <= '0;
    end else begin
      cnt_q <= cnt_sum[FT_W-1:0];
      if (tick) tcnt_q <= tcnt_nxt[TT_W-1:0];
    end
  end
endmodule

// File: rtl/irq_evt_reg.sv
module irq_evt_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] evt_o,
  output logic         irq_o
);
  logic [W-1:0] evt_q, mask_q, clr_m;

  assign clr_m = clr_we_i ? clr_i : '0;
  assign evt_o = evt_q;
  assign irq_o = |(evt_q & mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_q  <= '0;
      mask_q <= '0;
    end else begin
      evt_q <= (evt_q & ~clr_m) | set_i;  // set wins
      if (mask_we_i) mask_q <= mask_i;
    end
  end
endmodule

// File: rtl/irq_coal_top.sv
module irq_coal_top
  import irq_coal_pkg::*;
#(
  parameter int unsigned DIV    = 64,
  parameter int unsigned RX_BIT = 25,
  parameter int unsigned TX_BIT = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             rx_frame_i,
  input  logic             tx_frame_i,
  input  logic             alt_tick_i,
  input  logic             evt_clr_we_i,
  input  logic [CFG_W-1:0] evt_clr_i,
  input  logic             mask_we_i,
  input  logic [CFG_W-1:0] mask_i,
  output logic [CFG_W-1:0] evt_o,
  output logic             irq_o
);
  localparam int unsigned NDIR = 2;

  logic [NDIR-1:0]  frame, fire, pend, en;
  logic [CFG_W-1:0] set_vec;

  assign frame = {tx_frame_i, rx_frame_i};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    irq_coal_unit #(.DIV(DIV)) u_unit (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we_i[d]),
      .cfg_wdata_i(cfg_wdata_i),
      .frame_i    (frame[d]),
      .alt_tick_i (alt_tick_i),
      .fire_o     (fire[d]),
      .pend_o     (pend[d]),
      .en_o       (en[d])
    );
  end

  always_comb begin
    set_vec         = '0;
    set_vec[RX_BIT] = fire[0];
    set_vec[TX_BIT] = fire[1];
  end

  irq_evt_reg #(.W(CFG_W)) u_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clr_we_i (evt_clr_we_i),
    .clr_i    (evt_clr_i),
    .mask_we_i(mask_we_i),
    .mask_i   (mask_i),
    .evt_o    (evt_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/irq_coal_chk.sv
module irq_coal_chk #(
  parameter int unsigned RX_BIT = 25,
  parameter int unsigned TX_BIT = 27,
  parameter int unsigned W      = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [1:0]   frame_i,
  input logic [1:0]   fire_i,
  input logic [1:0]   pend_i,
  input logic [1:0]   en_i,
  input logic         evt_clr_we_i,
  input logic [W-1:0] evt_clr_i,
  input logic [W-1:0] evt_i,
  input logic         irq_i
);
  for (genvar d = 0; d < 2; d++) begin : g_d
    localparam int unsigned B = (d == 0) ? RX_BIT : TX_BIT;

    // R2
    dis_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[d] && frame_i[d] |=> evt_i[B]);
    // R8
    clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_clr_we_i && evt_clr_i[B] && !fire_i[d] |=> !evt_i[B]);
    // R8
    set_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fire_i[d] |=> evt_i[B]);
    // R5
    idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i[d] && !pend_i[d] && !frame_i[d] |-> !fire_i[d]);
    // R7
    rst_after_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i[d] && fire_i[d] |=> !pend_i[d]);
    // R9
    rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(evt_i[B]) |-> $past(fire_i[d]));
  end

  // R9
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (evt_i != '0));
endmodule

bind irq_coal_top irq_coal_chk #(.RX_BIT(RX_BIT), .TX_BIT(TX_BIT), .W(CFG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_i     (frame),
  .fire_i      (fire),
  .pend_i      (pend),
  .en_i        (en),
  .evt_clr_we_i(evt_clr_we_i),
  .evt_clr_i   (evt_clr_i),
  .evt_i       (evt_o),
  .irq_i       (irq_o)
);

// File: tb/tb_irq_coal_top.sv
module tb_irq_coal_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  cfg_we = '0;
  logic [31:0] cfg_wdata = '0;
  logic        rx = 1'b0, tx = 1'b0, alt = 1'b0;
  logic        clr_we = 1'b0, mask_we = 1'b0;
  logic [31:0] clr_v = '0, mask_v = '0;
  logic [31:0] evt_o;
  logic        irq_o;

  always #10 clk = ~clk;

  irq_coal_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .rx_frame_i(rx), .tx_frame_i(tx), .alt_tick_i(alt),
    .evt_clr_we_i(clr_we), .evt_clr_i(clr_v),
    .mask_we_i(mask_we), .mask_i(mask_v), .evt_o(evt_o), .irq_o(irq_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int b; int c; string req; } exp_t;
  exp_t q[$];
  int total = 0, bad = 0;
  logic [31:0] prev = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: each rising event bit must match the head of the queue
  always @(negedge clk) if (rst_ni) begin
    logic [31:0] rise;
    rise = evt_o & ~prev;
    prev = evt_o;
    for (int b = 0; b < 32; b++) if (rise[b]) begin
      if (q.size() == 0) chk(0, "spurious event", b, cyc);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(e.b == b && e.c == cyc, e.req, (b << 24) | cyc, (e.b << 24) | e.c);
      end
    end
  end

  // R3: en=31, cs=30, ft=[29:20], tt=[19:0]
  function automatic logic [31:0] cfgw(bit en, bit cs, int ft, int tt);
    return {en, cs, 10'(ft), 20'(tt)};
  endfunction

  // off < 0: no event expected from this frame
  task automatic pulse(input int d, input int off, input string req);
    @(negedge clk);
    if (d == 0) rx = 1'b1; else tx = 1'b1;
    if (off >= 0) q.push_back('{(d == 0) ? 25 : 27, cyc + off, req});
    @(negedge clk);
    rx = 1'b0; tx = 1'b0;
  endtask

  task automatic wcfg(input int d, input logic [31:0] v);
    @(negedge clk); cfg_we[d] = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = '0;
  endtask

  task automatic clr(input int b);
    @(negedge clk); clr_we = 1'b1; clr_v = 32'h1 << b;
    @(negedge clk); clr_we = 1'b0; clr_v = '0;
  endtask

  task automatic wmask(input logic [31:0] v);
    @(negedge clk); mask_we = 1'b1; mask_v = v;
    @(negedge clk); mask_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    chk(evt_o == '0, "R1 evt", evt_o, 0);
    chk(irq_o == 1'b0, "R1 irq", irq_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    idle(2);
    chk(evt_o == '0, "R1 evt after release", evt_o, 0);

    // R2 disabled pass-through
    pulse(0, 1, "R2 rx immediate");
    idle(1);
    chk(evt_o == 32'h1 << 25, "R2 rx bit", evt_o, 32'h1 << 25);
    chk(irq_o == 1'b0, "R9 masked", irq_o, 0);
    wmask(32'h1 << 27); idle(1);
    chk(irq_o == 1'b0, "R9 other mask bit", irq_o, 0);
    wmask(32'h1 << 25); idle(1);
    chk(irq_o == 1'b1, "R9 unmasked", irq_o, 1);
    clr(25); idle(1);
    chk(evt_o == '0, "R8 w1c", evt_o, 0);
    chk(irq_o == 1'b0, "R9 cleared", irq_o, 0);

    pulse(1, 1, "R10 tx immediate");
    idle(1);
    chk(evt_o == 32'h1 << 27, "R10 tx bit", evt_o, 32'h1 << 27);
    clr(27);

    // R8 set wins over same-cycle clear
    @(negedge clk);
    rx = 1'b1; clr_we = 1'b1; clr_v = 32'h1 << 25;
    q.push_back('{25, cyc + 1, "R8 set wins"});
    @(negedge clk); rx = 1'b0; clr_we = 1'b0; clr_v = '0;
    chk(evt_o[25] == 1'b1, "R8 set over clear", evt_o, 32'h1 << 25);
    clr(25);

    // R4 frame threshold 3, two rounds (R7 restart)
    wcfg(0, cfgw(1, 0, 3, 1000));
    pulse(0, -1, ""); pulse(0, -1, "");
    pulse(0, 1, "R3 R4 third frame");
    clr(25);
    pulse(0, -1, ""); pulse(0, -1, "");
    idle(50);
    chk(evt_o == '0, "R7 count restarted", evt_o, 0);
    pulse(0, 1, "R7 second round");
    clr(25);

    // R4 zero threshold acts as one
    wcfg(0, cfgw(1, 0, 0, 1000));
    pulse(0, 1, "R4 zero threshold");
    clr(25);

    // R5 timer on tx, T=2: fire 128 cycles after first frame edge
    wcfg(1, cfgw(1, 0, 10, 2));
    pulse(1, 1 + 128, "R5 timeout");
    idle(20);
    pulse(1, -1, "");
    idle(120);
    chk(evt_o == 32'h1 << 27, "R5 timeout bit", evt_o, 32'h1 << 27);
    clr(27);
    idle(300);
    chk(evt_o == '0, "R5 idle no timer", evt_o, 0);

    // R7 setting write drops waiting frames
    wcfg(0, cfgw(1, 0, 2, 1000));
    pulse(0, -1, "");
    wcfg(0, cfgw(1, 0, 2, 1000));
    pulse(0, -1, "");
    idle(5);
    chk(evt_o == '0, "R7 cfg clears count", evt_o, 0);
    pulse(0, 1, "R7 after rewrite");
    clr(25);

    // R6 alternate clock select
    wcfg(0, cfgw(1, 1, 10, 1));
    pulse(0, -1, "");
    idle(200);
    chk(evt_o == '0, "R6 no tick no timeout", evt_o, 0);
    @(negedge clk);
    alt = 1'b1;
    q.push_back('{25, cyc + 64, "R6 alt tick timeout"});
    idle(70);
    chk(evt_o[25] == 1'b1, "R6 fired", evt_o, 32'h1 << 25);
    alt = 1'b0;
    clr(25);

    idle(5);
    chk(q.size() == 0, "R4 missing events", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule